// File: doc/BRIEF.md
# Two-Thread Run-Ahead Address Queue Arbiter

This block is the shared next-address stage of a front end that serves two hardware threads. Each thread keeps a current fetch address and owns a private queue of predicted addresses. On every cycle an arbiter picks at most one thread. It shows that thread's current address to an external predictor port, which returns the next address in the same cycle. That returned address is appended to the chosen thread's queue and becomes the thread's new current address. The ownership can move to the other thread on the very next cycle, with no idle cycle between threads.

Fetch drains each queue on its own side through a valid/ready handshake, so each queue decouples prediction from fetch. The generator keeps running ahead while a queue has room. Each queue obeys these back-pressure rules. An entry leaves the queue only on a cycle where both valid and ready are high. Valid never depends on ready. A full queue stops further prediction for its thread. The choice between threads weighs stall status, queue occupancy and fairness. A per-thread redirect discards that thread's queue and restarts it from a new address.

Top module: `pq_arb_top`

## Requirements
- R1: Out of reset both queues are empty (empty flags 11, valid 00, full 00), no prediction request is issued while both threads are stalled, and both current addresses are 0.
- R2: A thread is eligible in a cycle only if its stall input is low, its queue is not full and its redirect input is low. `pred_valid_o` is high exactly when at least one thread is eligible, and only an eligible thread is granted. `pred_tid_o` gives the thread that is granted: 0 or 1.
- R3: While a thread is granted, `pred_cur_o` shows its current address. At the next edge `pred_next_i` is written at the tail of that thread's queue and becomes the thread's current address.
- R4: When both threads are eligible and neither is under the starvation rule of R7, the thread whose queue holds fewer entries (counted before this cycle's pop) is granted.
- R5: When both threads are eligible with equal occupancy and no starvation override, the thread not granted most recently wins. After reset, thread 0 wins the first tie.
- R6: When no thread is eligible, no queue is written and the tie-break memory keeps its value.
- R7: A thread that stays eligible is never denied for more than 2 consecutive cycles. After 2 denied eligible cycles it is granted regardless of occupancy.
- R8: A redirect empties that thread's queue at the next edge, loads the redirect address as its current address, and ignores that thread's ready in the same cycle. The other thread's queue and address are unchanged.
- R9: `q_valid_o[t]` is high exactly when queue t is not empty, and its head appears on `q_addr_o[t*48 +: 48]`. An entry is removed when valid and ready are both high. Entries leave in the order they were written, and each queue is independent of the other.
- R10: `q_full_o[t]` is high exactly when queue t holds 8 entries, and `q_empty_o[t]` is high exactly when it holds none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall_i | input | 2 | Per-thread stall, bit t for thread t |
| redir_valid_i | input | 2 | Per-thread redirect strobe |
| redir_addr_i | input | 96 | Redirect addresses, thread t in bits t*48 +: 48 |
| pred_valid_o | output | 1 | A thread is granted this cycle |
| pred_tid_o | output | 1 | Granted thread |
| pred_cur_o | output | 48 | Current address of the granted thread |
| pred_next_i | input | 48 | Next address from the external predictor, same cycle |
| q_valid_o | output | 2 | Queue head valid, per thread |
| q_ready_i | input | 2 | Fetch ready, per thread |
| q_addr_o | output | 96 | Queue heads, thread t in bits t*48 +: 48 |
| q_full_o | output | 2 | Queue full, per thread |
| q_empty_o | output | 2 | Queue empty, per thread |

## Verification
The grant, `pred_tid_o` and `pred_cur_o` react to inputs in the same cycle. A push, a pop, a redirect flush and an update of the current address appear one edge later. The bench drives inputs after a falling edge and compares every output 1 ns later against a model that it then advances at the rising edge. In this way each result is checked in the cycle where it is due. Starvation is measured from the observed grants alone: the bench counts the consecutive cycles in which a thread is eligible but not granted.

// File: rtl/pq_pkg.sv
package pq_pkg;
  localparam int unsigned NTHR = 2;
  typedef enum logic {THR0 = 1'b0, THR1 = 1'b1} thr_e;
endpackage

// File: rtl/pq_fifo.sv
module pq_fifo #(
  parameter int unsigned AW    = 48,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [AW-1:0] push_data,
  input  logic          pop,
  output logic [AW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;
  assign head    = mem[rd_q];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      count <= '0;
    end else if (flush) begin
      rd_q  <= '0;
      wr_q  <= '0;
      count <= '0;
    end else begin
      if (do_push) wr_q <= bump(wr_q);
      if (do_pop)  rd_q <= bump(rd_q);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data;
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !push && pop && !empty) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/pq_pick.sv
module pq_pick #(
  parameter int unsigned CW         = 4,
  parameter int unsigned STARVE_MAX = 2,
  localparam int unsigned WW        = $clog2(STARVE_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    elig,
  input  logic [CW-1:0] cnt0,
  input  logic [CW-1:0] cnt1,
  output logic [1:0]    gnt
);
  import pq_pkg::*;
  thr_e          last_q;
  logic [WW-1:0] wait_q [2];
  logic [1:0]    forced;

  generate
    for (genvar t = 0; t < 2; t++) begin : g_wait
      assign forced[t] = elig[t] && (wait_q[t] >= WW'(STARVE_MAX));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   wait_q[t] <= '0;
        else if (elig[t] && !gnt[t])  wait_q[t] <= (wait_q[t] >= WW'(STARVE_MAX)) ? wait_q[t] : wait_q[t] + 1'b1;
        else                          wait_q[t] <= '0;
      end
      // R7
      starve_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        forced[t] |-> gnt[t]);
    end
  endgenerate

  always_comb begin
    gnt = 2'b00;
    if (&elig) begin
      if (forced[0])         gnt = 2'b01;
      else if (forced[1])    gnt = 2'b10;
      else if (cnt0 < cnt1)  gnt = 2'b01;
      else if (cnt1 < cnt0)  gnt = 2'b10;
      else                   gnt = (last_q == THR1) ? 2'b01 : 2'b10;
    end else if (elig[0]) begin
      gnt = 2'b01;
    end else if (elig[1]) begin
      gnt = 2'b10;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    last_q <= THR1;
    else if (|gnt) last_q <= gnt[1] ? THR1 : THR0;
  end

  // R2
  grant_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && ((gnt & ~elig) == 2'b00));
  // R6
  rr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elig == 2'b00) |=> $stable(last_q));
endmodule

// File: rtl/pq_arb_top.sv
module pq_arb_top #(
  parameter int unsigned AW         = 48,
  parameter int unsigned DEPTH      = 8,
  parameter int unsigned STARVE_MAX = 2,
  localparam int unsigned CW        = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      stall_i,
  input  logic [1:0]      redir_valid_i,
  input  logic [2*AW-1:0] redir_addr_i,
  output logic            pred_valid_o,
  output logic            pred_tid_o,
  output logic [AW-1:0]   pred_cur_o,
  input  logic [AW-1:0]   pred_next_i,
  output logic [1:0]      q_valid_o,
  input  logic [1:0]      q_ready_i,
  output logic [2*AW-1:0] q_addr_o,
  output logic [1:0]      q_full_o,
  output logic [1:0]      q_empty_o
);
  logic [AW-1:0] cur_q [2];
  logic [CW-1:0] cnt   [2];
  logic [1:0]    elig, gnt;

  generate
    for (genvar t = 0; t < 2; t++) begin : g_thr
      assign elig[t]      = ~stall_i[t] & ~q_full_o[t] & ~redir_valid_i[t];
      assign q_valid_o[t] = ~q_empty_o[t];

      pq_fifo #(.AW(AW), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (redir_valid_i[t]),
        .push      (gnt[t]),
        .push_data (pred_next_i),
        .pop       (q_ready_i[t]),
        .head      (q_addr_o[t*AW +: AW]),
        .count     (cnt[t]),
        .full      (q_full_o[t]),
        .empty     (q_empty_o[t])
      );

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cur_q[t] <= '0;
        else if (redir_valid_i[t]) cur_q[t] <= redir_addr_i[t*AW +: AW];
        else if (gnt[t])           cur_q[t] <= pred_next_i;
      end

      // R3
      cur_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt[t] |=> (cur_q[t] == $past(pred_next_i)));
      // R8
      redir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid_i[t] |=> (cur_q[t] == $past(redir_addr_i[t*AW +: AW])));
    end
  endgenerate

  pq_pick #(.CW(CW), .STARVE_MAX(STARVE_MAX)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .elig  (elig),
    .cnt0  (cnt[0]),
    .cnt1  (cnt[1]),
    .gnt   (gnt)
  );

  assign pred_valid_o = |gnt;
  assign pred_tid_o   = gnt[1];
  assign pred_cur_o   = gnt[1] ? cur_q[1] : cur_q[0];

  // R8
  other_thread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid_i[0] && !redir_valid_i[1] && !gnt[1]) |=> $stable(cur_q[1]));
endmodule

// File: tb/pq_arb_top_test.sv
`timescale 1ns/1ps
module pq_arb_top_test;
  localparam int AW = 48;
  localparam int D  = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      stall, rv, ready;
  logic [2*AW-1:0] ra;
  logic            pv, ptid;
  logic [AW-1:0]   pcur, pnext;
  logic [1:0]      qv, qf, qe;
  logic [2*AW-1:0] qa;

  always #2 clk = ~clk;
  assign pnext = pcur + 48'd16;

  pq_arb_top uut (
    .clk(clk), .rst_n(rst_n), .stall_i(stall), .redir_valid_i(rv),
    .redir_addr_i(ra), .pred_valid_o(pv), .pred_tid_o(ptid),
    .pred_cur_o(pcur), .pred_next_i(pnext), .q_valid_o(qv),
    .q_ready_i(ready), .q_addr_o(qa), .q_full_o(qf), .q_empty_o(qe));

  int runs = 0, fails = 0, cyc = 0;
  logic [AW-1:0] mq [2][D];
  int            mhd [2], mcnt [2], mwait [2], obs_loss [2];
  logic [AW-1:0] mcur [2];
  logic          mlast;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int t = 0; t < 2; t++) begin
      mhd[t] = 0; mcnt[t] = 0; mwait[t] = 0; obs_loss[t] = 0; mcur[t] = '0;
    end
    mlast = 1'b1;
  endtask

  task automatic step(input logic [1:0] st, input logic [1:0] rd,
                      input logic [1:0] rdir, input logic [AW-1:0] a0, input logic [AW-1:0] a1);
    logic [1:0] el, g;
    string tag;
    @(negedge clk);
    stall = st; ready = rd; rv = rdir; ra = {a1, a0};
    #1;
    for (int t = 0; t < 2; t++) el[t] = !st[t] && (mcnt[t] != D) && !rdir[t];
    g = 2'b00; tag = "R6";
    if (&el) begin
      if (mwait[0] >= 2)          begin g = 2'b01; tag = "R7"; end
      else if (mwait[1] >= 2)     begin g = 2'b10; tag = "R7"; end
      else if (mcnt[0] < mcnt[1]) begin g = 2'b01; tag = "R4"; end
      else if (mcnt[1] < mcnt[0]) begin g = 2'b10; tag = "R4"; end
      else begin g = mlast ? 2'b01 : 2'b10; tag = "R5"; end
    end else if (el[0]) begin g = 2'b01; tag = "R2"; end
    else if (el[1])     begin g = 2'b10; tag = "R2"; end
    check(pv == (|g), "R2", 64'(pv), 64'(|g));
    if (|g) begin
      check(ptid == g[1], tag, 64'(ptid), 64'(g[1]));
      check(pcur == mcur[g[1]], "R3", 64'(pcur), 64'(mcur[g[1]]));
    end
    for (int t = 0; t < 2; t++) begin
      check(qv[t] == (mcnt[t] != 0), "R9", 64'(qv[t]), 64'(mcnt[t] != 0));
      if (mcnt[t] != 0)
        check(qa[t*AW +: AW] == mq[t][mhd[t]], "R9", 64'(qa[t*AW +: AW]), 64'(mq[t][mhd[t]]));
      check(qf[t] == (mcnt[t] == D) && qe[t] == (mcnt[t] == 0), "R10",
            64'({qf[t], qe[t]}), 64'({mcnt[t] == D, mcnt[t] == 0}));
      if (el[t] && !g[t]) obs_loss[t]++; else obs_loss[t] = 0;
      check(obs_loss[t] <= 2, "R7", 64'(obs_loss[t]), 64'd2);
    end
    @(posedge clk);
    cyc++;
    for (int t = 0; t < 2; t++) begin
      if (rdir[t]) begin
        mcnt[t] = 0; mhd[t] = 0; mcur[t] = t ? a1 : a0;
      end else begin
        if (g[t]) begin
          mq[t][(mhd[t] + mcnt[t]) % D] = mcur[t] + 48'd16;
          mcur[t] = mcur[t] + 48'd16;
        end
        if (rd[t] && mcnt[t] != 0) begin
          mhd[t] = (mhd[t] + 1) % D; mcnt[t]--;
        end
        if (g[t]) mcnt[t]++;
      end
      if (el[t] && !g[t]) mwait[t] = (mwait[t] >= 2) ? 2 : mwait[t] + 1;
      else mwait[t] = 0;
    end
    if (|g) mlast = g[1];
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++; runs++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin : main
    logic [15:0] lf;
    stall = 2'b11; rv = 2'b00; ready = 2'b00; ra = '0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(qe == 2'b11 && qv == 2'b00 && qf == 2'b00 && !pv, "R1",
          64'({qe, qv, qf, pv}), 64'({2'b11, 2'b00, 2'b00, 1'b0}));
    @(negedge clk); rst_n = 1'b1;
    // R5 ties alternate from thread 0, then both fill and R6 idles
    for (int i = 0; i < 20; i++) step(2'b00, 2'b00, 2'b00, '0, '0);
    check(qf == 2'b11, "R6", 64'(qf), 64'd3);
    // R9 drain one side only
    for (int i = 0; i < 6; i++) step(2'b00, 2'b01, 2'b00, '0, '0);
    // R8 redirect thread 0 while popping it
    step(2'b11, 2'b11, 2'b01, 48'h0000_1234_5000, '0);
    #1;
    check(qe[0] == 1'b1, "R8", 64'(qe[0]), 64'd1);
    check(qe[1] == 1'b0, "R8", 64'(qe[1]), 64'd0);
    for (int i = 0; i < 6; i++) step(2'b10, 2'b00, 2'b00, '0, '0);
    // R7 thread 1 drained every cycle keeps low occupancy; thread 0 still served
    step(2'b00, 2'b00, 2'b10, '0, 48'h0000_0000_9000);
    for (int i = 0; i < 30; i++) step(2'b00, 2'b10, 2'b00, '0, '0);
    // near-exhaustive sweep of stall/ready/redirect patterns
    for (int p = 0; p < 64; p++)
      for (int k = 0; k < 8; k++)
        step(p[1:0], p[3:2], (k == 0) ? p[5:4] : 2'b00, 48'(p * 4096), 48'(p * 8192 + 64));
    lf = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[1:0] & lf[3:2], lf[5:4] | lf[7:6], (lf[11:8] == 4'h0) ? lf[13:12] : 2'b00,
           48'(lf) << 4, 48'(~lf) << 4);
    end
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule